// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Unit

This block gathers event flags raised by peripherals, qualifies each with its own mask bit and with a global interrupt enable, and chooses one winner by fixed priority. When the CPU takes the request at an instruction boundary, the unit returns the winning vector address, clears the global enable, and clears the winning flag in hardware. Software clears a flag by writing a one to it. A return-from-interrupt sequence sets the global enable again after a fixed number of cycles.

Source bit i of the flag and mask registers maps to vector index i+1. Index 0 is the reset vector, which cannot be masked and which `vec_o` holds after reset. The vector address is the index multiplied by `VEC_SPACING`. Lower indices win. Bits listed in `RSVD_MASK` are unimplemented. The default layout reserves bit 1, so the eight-bit default fits a timer flag register that has one unused position.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset, flag_o, mask_o, gie_o, irq_o and ack_o are all 0, and vec_o is 0, which is the reset vector.
- R2: A high src_set_i bit sets its flag. When flag_wr_i is high, every flag whose wdata_i bit is 1 clears and every flag whose wdata_i bit is 0 is left alone. If a set and a clear hit the same bit in the same cycle, the set wins. Writing the current flag value back, with extra bits ORed in, therefore clears every flag that was set.
- R3: When mask_wr_i is high, wdata_i is loaded into the mask register. irq_o is high exactly when gie_o is 1 and at least one flag bit has its mask bit set.
- R4: Among pending, unmasked flags, the lowest bit index wins. The vector delivered for bit i is (i+1)*VEC_SPACING (default spacing 2).
- R5: Accept happens at the edge where both irq_o and take_i are high. In the cycle after accept, ack_o is 1 for exactly one cycle, vec_o holds the winner's vector, gie_o is 0, and the winner's flag is cleared. take_i has no effect while irq_o is low.
- R6: A request that becomes pending while gie_o is 0 stays pending. It raises irq_o as soon as gie_o returns to 1.
- R7: gie_set_i sets gie_o and gie_clr_i clears it, taking effect at the next edge. If both are high, the clear wins.
- R8: reti_i, when sampled at edge t, makes gie_o read 1 after edge t+RET_CYCLES-1 (default 4 edges in all). A reti_i that arrives while a return is in progress is ignored.
- R9: Bits marked in RSVD_MASK (default bit 1) never set in flag_o and always read 0 in mask_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | N_SRC | Flag set strobes from peripherals |
| flag_wr_i | input | 1 | Write-one-to-clear strobe for the flag register |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| wdata_i | input | N_SRC | Write data for flag or mask register |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| reti_i | input | 1 | Start of return from interrupt |
| take_i | input | 1 | CPU is ready to accept a pending interrupt |
| flag_o | output | N_SRC | Flag register contents |
| mask_o | output | N_SRC | Mask register contents |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request to the CPU |
| ack_o | output | 1 | One-cycle accept pulse |
| vec_o | output | ADDR_W | Vector address of the last accepted source |

## Verification
A fault in the priority encoder shows up at the next accept as a wrong vec_o, or as the wrong bit cleared in flag_o, one cycle after take_i. A flag or mask bit stuck at a wrong value shows up immediately, either as a wrong irq_o level or as a wrong register read. A broken return counter moves the rise of gie_o off its exact edge, which is detectable within RET_CYCLES cycles of reti_i. Checks are placed at each of these edges, including the set-versus-clear collision and the read-modify-write flag clearing.

// File: rtl/irq_pkg.sv
package irq_pkg;
  function automatic int unsigned vec_of(int unsigned idx, int unsigned spacing);
    return idx * spacing;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC     = 8,
  parameter logic [N_SRC-1:0] RSVD_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_set_i,
  input  logic             flag_wr_i,
  input  logic             mask_wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] hw_clr_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] mask_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    if (RSVD_MASK[g]) begin : g_rsvd
      assign flag_o[g] = 1'b0;
      assign mask_o[g] = 1'b0;
    end else begin : g_impl
      logic flag_q, mask_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= 1'b0;
          mask_q <= 1'b0;
        end else begin
          // new event wins over a clear in the same cycle
          if (src_set_i[g])                                 flag_q <= 1'b1;
          else if ((flag_wr_i && wdata_i[g]) || hw_clr_i[g]) flag_q <= 1'b0;
          if (mask_wr_i) mask_q <= wdata_i[g];
        end
      end
      assign flag_o[g] = flag_q;
      assign mask_o[g] = mask_q;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] oh_o
);
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    // scan high to low so the lowest set bit is written last
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        oh_o  = '0;
        oh_o[i] = 1'b1;
      end
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/irq_ret_timer.sv
module irq_ret_timer #(
  parameter int unsigned RET_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(RET_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!busy_o && start_i) cnt_q <= CNT_W'(RET_CYCLES - 1);
    else if (busy_o)             cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit #(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned VEC_SPACING = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned RET_CYCLES  = 4,
  parameter logic [N_SRC-1:0] RSVD_MASK = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_set_i,
  input  logic              flag_wr_i,
  input  logic              mask_wr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              reti_i,
  input  logic              take_i,
  output logic [N_SRC-1:0]  flag_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              gie_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] vec_o
);
  import irq_pkg::*;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] req, win_oh, hw_clr;
  logic [IDX_W-1:0] win_idx;
  logic             any_req, accept, ret_done, ret_busy;
  logic             gie_q, ack_q;
  logic [ADDR_W-1:0] vec_q;

  irq_flag_bank #(.N_SRC(N_SRC), .RSVD_MASK(RSVD_MASK)) u_bank (
    .clk_i, .rst_ni, .src_set_i, .flag_wr_i, .mask_wr_i, .wdata_i,
    .hw_clr_i(hw_clr), .flag_o, .mask_o
  );

  assign req = flag_o & mask_o;

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req_i(req), .valid_o(any_req), .idx_o(win_idx), .oh_o(win_oh)
  );

  irq_ret_timer #(.RET_CYCLES(RET_CYCLES)) u_ret (
    .clk_i, .rst_ni, .start_i(reti_i), .busy_o(ret_busy), .done_o(ret_done)
  );

  assign irq_o  = gie_q && any_req;
  assign accept = irq_o && take_i;
  assign hw_clr = accept ? win_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept) vec_q <= ADDR_W'(vec_of(32'(win_idx) + 1, VEC_SPACING));
      if (accept || gie_clr_i)         gie_q <= 1'b0;
      else if (gie_set_i || ret_done)  gie_q <= 1'b1;
    end
  end

  assign gie_o = gie_q;
  assign ack_o = ack_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_vec_unit_chk.sv
module irq_vec_unit_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              take_i,
  input logic              gie_clr_i,
  input logic              gie_o,
  input logic              irq_o,
  input logic              ack_o,
  input logic [ADDR_W-1:0] vec_o
);
  a_r5_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r5_ack_follows_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && take_i) |=> ack_o);
  a_r5_entry_clears_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !gie_o);
  a_r3_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_o);
  a_r4_vec_not_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (vec_o != '0));
  a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |=> !gie_o);
endmodule

bind irq_vec_unit irq_vec_unit_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_i), .gie_clr_i(gie_clr_i),
  .gie_o(gie_o), .irq_o(irq_o), .ack_o(ack_o), .vec_o(vec_o)
);

// File: tb/irq_vec_unit_tb.sv
module irq_vec_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  src_set_i = '0, wdata_i = '0;
  logic        flag_wr_i = 0, mask_wr_i = 0, gie_set_i = 0, gie_clr_i = 0;
  logic        reti_i = 0, take_i = 0;
  logic [7:0]  flag_o, mask_o;
  logic        gie_o, irq_o, ack_o;
  logic [11:0] vec_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  irq_vec_unit u_dut (.*);

  localparam logic [7:0] RSVD = 8'h02;
  // {raised flags, mask, expected vector index (0 = none)}
  localparam logic [19:0] TAB [7] = '{
    {8'h81, 8'hFF, 4'd1}, {8'hF0, 8'hFF, 4'd5}, {8'hF0, 8'h60, 4'd6},
    {8'h0C, 8'h08, 4'd4}, {8'h02, 8'hFF, 4'd0}, {8'h80, 8'h7F, 4'd0},
    {8'h03, 8'hFF, 4'd1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nedge(); @(negedge clk_i); endtask

  task automatic clean();
    flag_wr_i = 1; mask_wr_i = 1; wdata_i = 8'hFF; gie_clr_i = 1;
    nedge();
    flag_wr_i = 0; mask_wr_i = 0; wdata_i = 0; gie_clr_i = 0;
  endtask

  task automatic raise(logic [7:0] p);
    src_set_i = p; nedge(); src_set_i = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    nedge(); nedge();
    // R1 reset state
    chk("R1 flag", flag_o, 0); chk("R1 mask", mask_o, 0); chk("R1 gie", gie_o, 0);
    chk("R1 irq", irq_o, 0); chk("R1 ack", ack_o, 0); chk("R1 vec", vec_o, 0);
    rst_ni = 1; nedge();

    // table walk: R3 R4 R5 R9
    for (int k = 0; k < 7; k++) begin
      logic [7:0] pat, msk; logic [3:0] idx;
      {pat, msk, idx} = TAB[k];
      clean();
      wdata_i = msk; mask_wr_i = 1; nedge(); mask_wr_i = 0; wdata_i = 0;
      raise(pat);
      chk("R9 flag rsvd", flag_o, pat & ~RSVD);
      chk("R9 mask rsvd", mask_o, msk & ~RSVD);
      chk("R6 no irq while gie clear", irq_o, 0);
      gie_set_i = 1; nedge(); gie_set_i = 0;
      chk("R3 irq level", irq_o, idx != 0);
      take_i = 1; nedge(); take_i = 0;
      chk("R5 ack", ack_o, idx != 0);
      if (idx != 0) begin
        chk("R4 vector", vec_o, idx * 2);
        chk("R5 gie cleared", gie_o, 0);
        chk("R5 winner flag cleared", flag_o, (pat & ~RSVD) & ~(8'h01 << (idx - 1)));
        nedge(); chk("R5 ack one cycle", ack_o, 0);
      end
    end

    // R2 write-one-to-clear
    clean();
    raise(8'h91);
    flag_wr_i = 1; wdata_i = 8'h00; nedge(); flag_wr_i = 0;
    chk("R2 zero write keeps flags", flag_o, 8'h91);
    v = flag_o | 8'h04;
    flag_wr_i = 1; wdata_i = v; nedge(); flag_wr_i = 0;
    chk("R2 rmw clears all set flags", flag_o, 0);
    src_set_i = 8'h10; flag_wr_i = 1; wdata_i = 8'h10; nedge();
    src_set_i = 0; flag_wr_i = 0;
    chk("R2 set wins collision", flag_o, 8'h10);

    // R7 clear beats set
    gie_set_i = 1; gie_clr_i = 1; nedge(); gie_set_i = 0; gie_clr_i = 0;
    chk("R7 clear wins", gie_o, 0);

    // R6 pending while gie clear, R5 take without irq
    clean();
    mask_wr_i = 1; wdata_i = 8'hFF; nedge(); mask_wr_i = 0;
    raise(8'h20);
    v = vec_o;
    take_i = 1; nedge(); take_i = 0;
    chk("R5 take without irq no ack", ack_o, 0);
    chk("R5 take without irq keeps vec", vec_o, v);
    chk("R6 still pending", flag_o, 8'h20);
    gie_set_i = 1; nedge(); gie_set_i = 0;
    chk("R6 irq after gie set", irq_o, 1);
    raise(8'h80);
    take_i = 1; nedge(); take_i = 0;
    chk("R6 pending taken vec", vec_o, 12);

    // R8 return timing with second reti ignored; R6 irq rises with gie
    chk("R8 gie low in handler", gie_o, 0);
    reti_i = 1; nedge();
    chk("R8 gie after 1 edge", gie_o, 0);
    nedge(); reti_i = 0;
    chk("R8 gie after 2 edges", gie_o, 0);
    nedge();
    chk("R8 gie after 3 edges", gie_o, 0);
    nedge();
    chk("R8 gie after 4 edges", gie_o, 1);
    chk("R6 irq on return", irq_o, 1);
    take_i = 1; nedge(); take_i = 0;
    chk("R4 next vector", vec_o, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule